// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master copy engine. Software places a list of descriptors in memory, one after another. Each descriptor names a source address, a destination address and a byte count. Software then loads a list pointer and issues a start command. The engine fetches each descriptor in turn and copies its data one word at a time through a single memory port. After it finishes the descriptor whose final flag is set, it stops and raises a completion interrupt.

The engine has two directions, read and write. Each direction has its own list pointer, its own enable bit, its own busy bit and its own data-error bit. Only one list runs at a time. A malformed descriptor or an error response from memory stops the list and raises an error interrupt. Software can interrupt a running list at any time with a cancel command, which also wipes the error history, or with a stop command, which keeps it.

The memory port uses a plain request/acknowledge handshake with word-wide data. The register port is a simple strobe interface: writes take effect at the clock edge, and read data is registered.

Top module: `sgdma_engine`

## Requirements
- R1: A descriptor is three consecutive words at the list pointer, in this order: source address, destination address, control. Control bits [15:0] hold the byte count and bit 31 marks the final descriptor. The next descriptor follows directly at pointer + 12.
- R2: Each descriptor copies byte_count/4 words. It reads the source and writes the destination at ascending consecutive word addresses.
- R3: When the descriptor with bit 31 set has been copied, busy clears and `irq_done` pulses for one cycle. No descriptor after it is fetched.
- R4: A byte count of zero, or one that is not a multiple of GRAN_BYTES (256), sets status bit 4 and pulses `irq_err`. The list then stops without copying that descriptor.
- R5: Writing 1 to the control register (offset 0) starts the read direction from the read list pointer (offset 3). Writing 2 starts the write direction from the write list pointer (offset 4). A start is ignored if the matching bit of the enable register (offset 2; bit 0 read, bit 1 write) is clear, or if the engine is already busy.
- R6: In the status register (offset 1), bit 0 shows busy in the read direction and bit 1 shows busy in the write direction. At most one of them is set.
- R7: An error response on a data access sets status bit 2 in the read direction or bit 3 in the write direction. Busy then clears, `irq_err` pulses and no further access is made.
- R8: Status bits 2 to 4 are write-one-to-clear. Writing 0 to a bit leaves it unchanged.
- R9: Control value 0 (cancel) halts the engine once the outstanding memory access has completed. Busy clears, no interrupt is raised, and all status error bits are cleared. The engine can then be started again.
- R10: Control value 4 (stop) halts the engine in the same way as cancel but keeps the status error bits.
- R11: Once `mem_req` is raised, it stays high with stable address, direction and write data until `mem_ack` is seen, and it is low whenever the engine is idle.
- R12: Register read data appears on `reg_rdata` one clock after the `reg_rd` strobe. After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_err | input | 1 | Error response, valid with ack |
| irq_done | output | 1 | One-cycle pulse at list completion |
| irq_err | output | 1 | One-cycle pulse at list abort |

## Verification
Two-descriptor lists are run in both directions. The copied regions, together with an untouched word that a third descriptor beyond the final one would have written, show whether the engine walks the list sequentially and honours the final flag. Bad lengths (a non-multiple of 256 and zero) and memory errors injected on a source read and on a destination write separate the list-error bit from the two data-error bits, and the partial copy reveals where the engine stopped. Start commands with enables clear, and stop and cancel issued mid-copy on top of a leftover error bit, show which commands are ignored and which commands preserve or wipe the error history.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SRC   = 2'd2,
    ST_DST   = 2'd3
  } walk_e;

  // register word offsets
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ENABLE = 3'd2;
  localparam logic [2:0] OFS_RDLIST = 3'd3;
  localparam logic [2:0] OFS_WRLIST = 3'd4;

  // control command codes
  localparam int CMD_CANCEL = 0;
  localparam int CMD_READ   = 1;
  localparam int CMD_WRITE  = 2;
  localparam int CMD_STOP   = 4;

endpackage

// File: rtl/sgdma_desc_check.sv
module sgdma_desc_check #(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int GRAN_BYTES = 256
) (
  input  logic [DATA_W-1:0]               ctl_word,
  output logic                            cnt_ok,
  output logic [CNT_W-$clog2(DATA_W/8)-1:0] word_cnt
);
  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam int WB_LSB   = $clog2(DATA_W/8);

  logic [CNT_W-1:0] bytes;

  always_comb begin
    bytes    = ctl_word[CNT_W-1:0];
    cnt_ok   = (bytes != '0) && (bytes[GRAN_LSB-1:0] == '0);
    word_cnt = bytes[CNT_W-1:WB_LSB];
  end
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  dir_e              eng_dir,
  input  logic              evt_lerr,
  input  logic              evt_derr,
  output logic              start,
  output dir_e              start_dir,
  output logic [ADDR_W-1:0] start_ptr,
  output logic              halt
);
  localparam int NERR = 3;  // 0: read data, 1: write data, 2: list

  logic [1:0]        enable_q;
  logic [ADDR_W-1:0] rd_list_q, wr_list_q;
  logic [NERR-1:0]   err_q, err_set, err_clr;
  logic              ctrl_wr, stat_wr, is_cancel, is_stop, go_rd, go_wr;
  logic [DATA_W-1:0] status_w;

  always_comb begin
    ctrl_wr   = reg_wr && (reg_addr == OFS_CTRL);
    stat_wr   = reg_wr && (reg_addr == OFS_STATUS);
    is_cancel = ctrl_wr && (reg_wdata == DATA_W'(CMD_CANCEL));
    is_stop   = ctrl_wr && (reg_wdata == DATA_W'(CMD_STOP));
    go_rd     = ctrl_wr && (reg_wdata == DATA_W'(CMD_READ))  && enable_q[0];
    go_wr     = ctrl_wr && (reg_wdata == DATA_W'(CMD_WRITE)) && enable_q[1];
    start     = (go_rd || go_wr) && !eng_busy;
    start_dir = go_wr ? DIR_WR : DIR_RD;
    start_ptr = go_wr ? wr_list_q : rd_list_q;
    halt      = is_cancel || is_stop;
    err_set   = {evt_lerr, evt_derr && (eng_dir == DIR_WR), evt_derr && (eng_dir == DIR_RD)};
    err_clr   = is_cancel ? '1 : (stat_wr ? reg_wdata[2 +: NERR] : '0);
    status_w  = '0;
    status_w[0] = eng_busy && (eng_dir == DIR_RD);
    status_w[1] = eng_busy && (eng_dir == DIR_WR);
    status_w[2 +: NERR] = err_q;
  end

  for (genvar g = 0; g < NERR; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)             err_q[g] <= 1'b0;
      else if (err_set[g]) err_q[g] <= 1'b1;
      else if (err_clr[g]) err_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= '0;
      rd_list_q <= '0;
      wr_list_q <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFS_ENABLE: enable_q  <= reg_wdata[1:0];
          OFS_RDLIST: rd_list_q <= reg_wdata[ADDR_W-1:0];
          OFS_WRLIST: wr_list_q <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          OFS_STATUS: reg_rdata <= status_w;
          OFS_ENABLE: reg_rdata <= DATA_W'(enable_q);
          OFS_RDLIST: reg_rdata <= DATA_W'(rd_list_q);
          OFS_WRLIST: reg_rdata <= DATA_W'(wr_list_q);
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int GRAN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  dir_e              start_dir,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic              halt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              busy,
  output dir_e              dir,
  output logic              evt_done,
  output logic              evt_lerr,
  output logic              evt_derr
);
  localparam int WB     = DATA_W / 8;
  localparam int WB_LSB = $clog2(WB);
  localparam int WC_W   = CNT_W - WB_LSB;

  walk_e             state;
  logic [ADDR_W-1:0] ptr_q, src_q, dst_q;
  logic [DATA_W-1:0] dbuf_q;
  logic [1:0]        fidx_q;
  logic              last_q, halt_pend;
  logic [WC_W-1:0]   wcnt_q, cnt_words;
  logic              cnt_ok, halt_now;

  sgdma_desc_check #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .GRAN_BYTES(GRAN_BYTES)
  ) u_desc (
    .ctl_word(mem_rdata),
    .cnt_ok  (cnt_ok),
    .word_cnt(cnt_words)
  );

  assign busy     = (state != ST_IDLE);
  assign halt_now = halt || halt_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dir       <= DIR_RD;
      ptr_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      dbuf_q    <= '0;
      fidx_q    <= '0;
      last_q    <= 1'b0;
      halt_pend <= 1'b0;
      wcnt_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      evt_done  <= 1'b0;
      evt_lerr  <= 1'b0;
      evt_derr  <= 1'b0;
    end else begin
      evt_done <= 1'b0;
      evt_lerr <= 1'b0;
      evt_derr <= 1'b0;
      if (state == ST_IDLE) begin
        halt_pend <= 1'b0;
        if (start) begin
          state  <= ST_FETCH;
          dir    <= start_dir;
          ptr_q  <= start_ptr;
          fidx_q <= '0;
        end
      end else begin
        if (halt) halt_pend <= 1'b1;
        if (!mem_req) begin
          // access boundary: either halt or issue the next access
          if (halt_now) begin
            state     <= ST_IDLE;
            halt_pend <= 1'b0;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= (state == ST_DST);
            mem_wdata <= dbuf_q;
            case (state)
              ST_FETCH: mem_addr <= ptr_q;
              ST_SRC:   mem_addr <= src_q;
              default:  mem_addr <= dst_q;
            endcase
          end
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          case (state)
            ST_FETCH: begin
              ptr_q  <= ptr_q + ADDR_W'(WB);
              fidx_q <= fidx_q + 2'd1;
              if (mem_err) begin
                evt_lerr <= 1'b1;
                state    <= ST_IDLE;
              end else if (fidx_q == 2'd0) begin
                src_q <= mem_rdata[ADDR_W-1:0];
              end else if (fidx_q == 2'd1) begin
                dst_q <= mem_rdata[ADDR_W-1:0];
              end else begin
                last_q <= mem_rdata[DATA_W-1];
                wcnt_q <= cnt_words;
                if (cnt_ok) begin
                  state <= ST_SRC;
                end else begin
                  evt_lerr <= 1'b1;
                  state    <= ST_IDLE;
                end
              end
            end
            ST_SRC: begin
              if (mem_err) begin
                evt_derr <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                dbuf_q <= mem_rdata;
                state  <= ST_DST;
              end
            end
            default: begin
              if (mem_err) begin
                evt_derr <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                src_q  <= src_q + ADDR_W'(WB);
                dst_q  <= dst_q + ADDR_W'(WB);
                wcnt_q <= wcnt_q - 1'b1;
                if (wcnt_q != WC_W'(1)) begin
                  state <= ST_SRC;
                end else if (last_q) begin
                  evt_done <= 1'b1;
                  state    <= ST_IDLE;
                end else begin
                  fidx_q <= '0;
                  state  <= ST_FETCH;
                end
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int GRAN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              irq_done,
  output logic              irq_err
);
  logic              eng_busy, start, halt, evt_done, evt_lerr, evt_derr;
  dir_e              eng_dir, start_dir;
  logic [ADDR_W-1:0] start_ptr;

  sgdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .eng_busy (eng_busy),
    .eng_dir  (eng_dir),
    .evt_lerr (evt_lerr),
    .evt_derr (evt_derr),
    .start    (start),
    .start_dir(start_dir),
    .start_ptr(start_ptr),
    .halt     (halt)
  );

  sgdma_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .GRAN_BYTES(GRAN_BYTES)
  ) u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .start_dir(start_dir),
    .start_ptr(start_ptr),
    .halt     (halt),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .mem_err  (mem_err),
    .busy     (eng_busy),
    .dir      (eng_dir),
    .evt_done (evt_done),
    .evt_lerr (evt_lerr),
    .evt_derr (evt_derr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= evt_done;
      irq_err  <= evt_lerr || evt_derr;
    end
  end
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              irq_done,
  input logic              irq_err,
  input logic              eng_busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !mem_req); // R11
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq_done && irq_err)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> $past(eng_busy, 2)); // R3
  AST_ERR_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(eng_busy, 2)); // R7
endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .irq_done (irq_done),
  .irq_err  (irq_err),
  .eng_busy (eng_busy)
);

// File: tb/sgdma_engine_test.sv
`timescale 1ns/1ps
module sgdma_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_done, irq_err;

  int errors = 0, checks = 0;
  int exp_q[$];           // 0 = done interrupt, 1 = error interrupt
  logic [31:0] mem [0:1023];
  logic        err_en = 1'b0;
  logic [9:0]  err_idx = '0;
  int          proto_bad = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  sgdma_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq_done(irq_done), .irq_err(irq_err)
  );

  // memory model: one-cycle acknowledge, optional error response on one word
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
      prev_wait <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_err <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (err_en && mem_addr[11:2] == err_idx) mem_err <= 1'b1;
        else if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:2]];
      end
      if (prev_wait && mem_req && mem_addr != prev_addr) proto_bad <= proto_bad + 1;
      prev_wait <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every interrupt must match the next expected kind
  always @(negedge clk) begin
    if (!rst && (irq_done || irq_err)) begin
      int kind;
      kind = (irq_done && irq_err) ? 2 : (irq_err ? 1 : 0);
      if (exp_q.size() == 0) check(1'b0, "R3/R9 unexpected interrupt", kind, 32'hffffffff);
      else begin
        int e;
        e = exp_q.pop_front();
        check(kind == e, "R3/R4/R7 interrupt kind", kind, e);
      end
    end
  end

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int at, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    mem[at >> 2] = s; mem[(at >> 2) + 1] = d; mem[(at >> 2) + 2] = c;
  endtask

  task automatic clear_dst();
    for (int i = 512; i < 1024; i++) mem[i] = '0;
  endtask

  // driver: push the expected interrupt, then issue the start command
  task automatic launch(input int cmd, input int kind);
    exp_q.push_back(kind);
    reg_write(3'd0, cmd);
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 20000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_copy(input int src, input int dst, input int bytes, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < bytes / 4; i++)
      if (mem[(dst >> 2) + i] !== mem[(src >> 2) + i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic expect_status(input logic [31:0] exp, input string tag);
    logic [31:0] v;
    reg_read(3'd1, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = (i >= 256 && i < 512) ? pat(i) : '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state, registered read path
    expect_status(32'h0, "R12 status after reset");
    reg_read(3'd2, v);
    check(v == 0, "R12 enable after reset", v, 0);
    check(!irq_done && !irq_err, "R12 interrupts idle after reset", {irq_done, irq_err}, 0);

    // two-descriptor read list; a third descriptor past the final one must be skipped
    put_desc(32'h000, 32'h400, 32'h800, 32'h0000_0100);
    put_desc(32'h00C, 32'h500, 32'hA00, 32'h8000_0200);
    put_desc(32'h018, 32'h400, 32'hE00, 32'h8000_0100);
    reg_write(3'd2, 32'h3);
    reg_write(3'd3, 32'h000);
    launch(1, 0);
    repeat (20) @(negedge clk);
    expect_status(32'h1, "R6 read busy bit");
    drain("R3 done interrupt for read list");
    expect_status(32'h0, "R3 idle after final descriptor");
    cmp_copy(32'h400, 32'h800, 256, "R2 first descriptor copy");
    cmp_copy(32'h500, 32'hA00, 512, "R1 second descriptor fetched at pointer+12");
    check(mem[32'hE00 >> 2] == 0, "R3 nothing fetched past final", mem[32'hE00 >> 2], 0);

    // starts ignored when the matching enable is clear
    clear_dst();
    reg_write(3'd2, 32'h0);
    reg_write(3'd0, 32'h1);
    reg_write(3'd2, 32'h2);
    reg_write(3'd0, 32'h1);
    repeat (30) @(negedge clk);
    expect_status(32'h0, "R5 start ignored with enable clear");
    check(mem[32'h800 >> 2] == 0, "R5 no copy with enable clear", mem[32'h800 >> 2], 0);

    // write direction uses its own list pointer
    reg_write(3'd2, 32'h3);
    put_desc(32'h040, 32'h400, 32'hC00, 32'h8000_0400);
    reg_write(3'd4, 32'h040);
    launch(2, 0);
    repeat (20) @(negedge clk);
    expect_status(32'h2, "R6 write busy bit");
    drain("R5 done interrupt for write list");
    cmp_copy(32'h400, 32'hC00, 1024, "R5 write list copy");

    // length not a multiple of 256
    clear_dst();
    put_desc(32'h060, 32'h400, 32'h800, 32'h8000_0180);
    reg_write(3'd3, 32'h060);
    launch(1, 1);
    drain("R4 error interrupt bad length");
    expect_status(32'h10, "R4 list error bit");
    check(mem[32'h800 >> 2] == 0, "R4 bad descriptor not copied", mem[32'h800 >> 2], 0);

    // write-one-to-clear
    reg_write(3'd1, 32'h0C);
    expect_status(32'h10, "R8 zero bits leave list error");
    reg_write(3'd1, 32'h10);
    expect_status(32'h0, "R8 one clears list error");

    // zero length
    put_desc(32'h070, 32'h400, 32'h800, 32'h8000_0000);
    reg_write(3'd3, 32'h070);
    launch(1, 1);
    drain("R4 error interrupt zero length");
    expect_status(32'h10, "R4 zero length list error");
    reg_write(3'd1, 32'h10);

    // memory error on a source read, read direction
    clear_dst();
    put_desc(32'h080, 32'h400, 32'h800, 32'h8000_0100);
    reg_write(3'd3, 32'h080);
    err_idx = 10'(32'h440 >> 2); err_en = 1'b1;
    launch(1, 1);
    drain("R7 error interrupt read data");
    expect_status(32'h04, "R7 read error bit");
    check(mem[32'h83C >> 2] == mem[32'h43C >> 2], "R7 words before error copied", mem[32'h83C >> 2], mem[32'h43C >> 2]);
    check(mem[32'h840 >> 2] == 0, "R7 no access after error", mem[32'h840 >> 2], 0);
    reg_write(3'd1, 32'h04);

    // memory error on a destination write, write direction
    clear_dst();
    put_desc(32'h090, 32'h400, 32'h800, 32'h8000_0100);
    reg_write(3'd4, 32'h090);
    err_idx = 10'(32'h810 >> 2);
    launch(2, 1);
    drain("R7 error interrupt write data");
    err_en = 1'b0;
    expect_status(32'h08, "R7 write error bit");

    // stop mid-copy keeps error history
    clear_dst();
    put_desc(32'h0A0, 32'h400, 32'h800, 32'h8000_0400);
    reg_write(3'd3, 32'h0A0);
    reg_write(3'd0, 32'h1);
    repeat (40) @(negedge clk);
    expect_status(32'h09, "R6 busy with leftover error");
    reg_write(3'd0, 32'h4);
    repeat (10) @(negedge clk);
    expect_status(32'h08, "R10 stop halts and keeps errors");
    check(mem[32'hBFC >> 2] == 0, "R10 copy halted early", mem[32'hBFC >> 2], 0);

    // cancel mid-copy wipes error history
    reg_write(3'd0, 32'h1);
    repeat (40) @(negedge clk);
    reg_write(3'd0, 32'h0);
    repeat (10) @(negedge clk);
    expect_status(32'h0, "R9 cancel halts and clears errors");

    // engine restarts after cancel
    clear_dst();
    reg_write(3'd3, 32'h000);
    launch(1, 0);
    drain("R9 restart after cancel");
    cmp_copy(32'h400, 32'h800, 256, "R9 copy after restart");

    check(proto_bad == 0, "R11 request held stable until ack", proto_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule